// File: doc/BRIEF.md
# Split Nibble Register File

The register file stores eight 4-bit entries. They can be reached in two ways. Eight narrow read ports and eight narrow write ports each work on the 4-bit entries. A narrow port picks its entries with an enable vector that has one bit per entry, not with a binary address. One wide read port and one wide write port see the whole array as a single 32-bit word. Entry i sits at bits [4*i+3 : 4*i] of that word.

Reads are combinational. A narrow read port returns the bitwise OR of every entry it enables. When a write targets an entry in the same cycle as a read, the read returns the data being written, not the stored value. Writes commit on the rising clock edge. When several writes target one entry in the same cycle, a fixed priority picks the winner: the narrow port with the lowest number wins, and any narrow port beats the wide port.

The block is meant for a pipeline whose dependency logic already works in bit vectors. Such logic can drive the enables directly, with no encoder in between.

Top module: `nibble_regfile`

## Requirements
- R1: Storage is eight 4-bit entries. Entry i maps to bits [4*i+3 : 4*i] of the 32-bit wide view, so entry 0 is the least significant nibble.
- R2: Narrow read port p outputs, with no clock delay, the OR of the values of every entry whose bit is set in its enable vector `nrd_sel[p]`. Bit i of the vector selects entry i. An all-zero enable vector gives zero.
- R3: When `wrd_en` is 1, the wide read port outputs all eight entry values as one 32-bit word. When `wrd_en` is 0, it outputs zero.
- R4: Narrow write port p updates, at the rising clock edge, every entry whose bit is set in `nwr_sel[p]`, loading the value on `nwr_data[p]`. The stored value can be read from the next cycle on.
- R5: When `wwr_en` is 1, the wide write updates all eight entries at the clock edge from the matching nibbles of `wwr_data`.
- R6: A read of an entry that is being written in the same cycle returns the winning write data. This holds for the narrow and the wide read ports.
- R7: When several narrow write ports target the same entry in one cycle, the port with the lowest number sets both the stored value and the forwarded value.
- R8: When the wide write and any narrow write target the same entry, the narrow data wins for that entry. Every other entry takes its nibble from the wide data.
- R9: When `rst_n` is low at a rising edge, all entries are cleared to zero.
- R10: An entry that no write targets keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| nrd_sel | input | 8x8 | Enable vector for each narrow read port (one bit per entry) |
| nrd_data | output | 8x4 | Result of each narrow read port |
| nwr_sel | input | 8x8 | Enable vector for each narrow write port (one bit per entry) |
| nwr_data | input | 8x4 | Data for each narrow write port |
| wrd_en | input | 1 | Enable for the wide read port |
| wrd_data | output | 32 | Wide read result |
| wwr_en | input | 1 | Enable for the wide write port |
| wwr_data | input | 32 | Wide write data |

## Verification
Every read result is due in the same cycle as the enables and write data that produce it, because forwarding sits in front of the storage. A write shows in storage only one rising edge later. The bench drives all inputs at the falling edge and computes the expected read values at once from a model that forwards the same way. It then updates the model state as the clock edge will. A monitor compares the queued expectations 3 ns later, which is still before the next rising edge. Each read therefore sees exactly the writes of earlier cycles plus the writes forwarded in the current one.

// File: rtl/nibrf_pkg.sv
// Package: default sizes shared by the split nibble register file and its bench.
package nibrf_pkg;
    parameter int NIB_ENTRIES = 8;   // number of storage entries
    parameter int NIB_WIDTH   = 4;   // bits per entry
    parameter int NIB_RPORTS  = 8;   // narrow read ports
    parameter int NIB_WPORTS  = 8;   // narrow write ports
endpackage

// File: rtl/nibrf_cell.sv
// Module: nibrf_cell
// What it does: holds one entry. It loads d when we is high and clears when rst_n is low.
// Assumes: reset is synchronous and active low, and takes priority over a write.
module nibrf_cell #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Storage update: reset first, then the write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/nibrf_wsel.sv
// Module: nibrf_wsel
// What it does: for one entry, picks the winning write and gives the value this entry shows
// in the current cycle (the write data if any write hits, otherwise the stored value).
// Assumes: the lowest-numbered narrow port has the highest priority, and any narrow port beats the wide port.
module nibrf_wsel #(
    parameter int NW = 8,
    parameter int W  = 4
) (
    input  logic [NW-1:0]        hit,
    input  logic [NW-1:0][W-1:0] ndata,
    input  logic                 wide_hit,
    input  logic [W-1:0]         wide_data,
    input  logic [W-1:0]         stored,
    output logic                 any_wr,
    output logic [W-1:0]         fwd
);
    // Priority pick: walk from the highest port down so the lowest port is applied last and wins.
    always_comb begin
        fwd    = wide_hit ? wide_data : stored;
        any_wr = wide_hit;
        for (int p = NW - 1; p >= 0; p--) begin
            if (hit[p]) begin
                fwd    = ndata[p];
                any_wr = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nibrf_rdmux.sv
// Module: nibrf_rdmux
// What it does: builds one narrow read result as the OR of the forwarded values of the enabled entries.
// Assumes: an entry that is not enabled adds zero.
module nibrf_rdmux #(
    parameter int NE = 8,
    parameter int W  = 4
) (
    input  logic [NE-1:0]        sel,
    input  logic [NE-1:0][W-1:0] vals,
    output logic [W-1:0]         dout
);
    // OR reduction of the gated entries.
    always_comb begin
        dout = '0;
        for (int e = 0; e < NE; e++) begin
            if (sel[e]) dout = dout | vals[e];
        end
    end
endmodule

// File: rtl/nibble_regfile.sv
// Module: nibble_regfile
// What it does: an eight-entry, 4-bit register file. Narrow ports pick entries with an enable
// vector (one bit per entry), and a wide port reads or writes all entries as one word.
// Reads forward same-cycle write data; writes commit at the clock edge.
// Assumes: entry i is nibble i of the wide word, and reset is synchronous and active low.
module nibble_regfile #(
    parameter int N_ENT = nibrf_pkg::NIB_ENTRIES,
    parameter int ENT_W = nibrf_pkg::NIB_WIDTH,
    parameter int N_RP  = nibrf_pkg::NIB_RPORTS,
    parameter int N_WP  = nibrf_pkg::NIB_WPORTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_RP-1:0][N_ENT-1:0]  nrd_sel,
    output logic [N_RP-1:0][ENT_W-1:0]  nrd_data,
    input  logic [N_WP-1:0][N_ENT-1:0]  nwr_sel,
    input  logic [N_WP-1:0][ENT_W-1:0]  nwr_data,
    input  logic                        wrd_en,
    output logic [N_ENT*ENT_W-1:0]      wrd_data,
    input  logic                        wwr_en,
    input  logic [N_ENT*ENT_W-1:0]      wwr_data
);
    localparam int WIDE_W = N_ENT * ENT_W;

    logic [N_ENT-1:0][ENT_W-1:0] stored;
    logic [N_ENT-1:0][ENT_W-1:0] fwd;
    logic [N_ENT-1:0]            ent_we;
    logic [N_ENT-1:0][N_WP-1:0]  ent_hit;

    // Transpose: turn the per-port enable vectors into per-entry hit vectors.
    always_comb begin
        for (int e = 0; e < N_ENT; e++)
            for (int p = 0; p < N_WP; p++)
                ent_hit[e][p] = nwr_sel[p][e];
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        nibrf_wsel #(.NW(N_WP), .W(ENT_W)) u_wsel (
            .hit       (ent_hit[e]),
            .ndata     (nwr_data),
            .wide_hit  (wwr_en),
            .wide_data (wwr_data[e*ENT_W +: ENT_W]),
            .stored    (stored[e]),
            .any_wr    (ent_we[e]),
            .fwd       (fwd[e])
        );
        nibrf_cell #(.W(ENT_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ent_we[e]),
            .d     (fwd[e]),
            .q     (stored[e])
        );
    end

    for (genvar p = 0; p < N_RP; p++) begin : g_rp
        nibrf_rdmux #(.NE(N_ENT), .W(ENT_W)) u_rd (
            .sel  (nrd_sel[p]),
            .vals (fwd),
            .dout (nrd_data[p])
        );
    end

    // Wide read: the whole forwarded array, or zero when not enabled.
    always_comb begin
        wrd_data = wrd_en ? WIDE_W'(fwd) : '0;
    end
endmodule

// File: rtl/nibrf_chk.sv
// Module: nibrf_chk
// What it does: port-level timing properties of nibble_regfile, attached to it with bind.
// Assumes: at least two narrow write ports, two entries and one read port.
module nibrf_chk #(
    parameter int N_ENT = 8,
    parameter int ENT_W = 4,
    parameter int N_RP  = 8,
    parameter int N_WP  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_RP-1:0][N_ENT-1:0]  nrd_sel,
    input logic [N_RP-1:0][ENT_W-1:0]  nrd_data,
    input logic [N_WP-1:0][N_ENT-1:0]  nwr_sel,
    input logic [N_WP-1:0][ENT_W-1:0]  nwr_data,
    input logic                        wrd_en,
    input logic [N_ENT*ENT_W-1:0]      wrd_data,
    input logic                        wwr_en,
    input logic [N_ENT*ENT_W-1:0]      wwr_data
);
    logic no_nwr;
    assign no_nwr = ~|nwr_sel;

    for (genvar p = 0; p < N_RP; p++) begin : g_zero
        assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (nrd_sel[p] == '0) |-> (nrd_data[p] == '0));
    end

    assert_wide_off_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wrd_en |-> (wrd_data == '0));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && wrd_en && !wwr_en && no_nwr) |-> (wrd_data == '0));

    assert_wide_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wwr_en && no_nwr && wrd_en) |-> (wrd_data == wwr_data));

    assert_wide_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wwr_en && no_nwr) ##1 (wrd_en && !wwr_en && no_nwr) |-> (wrd_data == $past(wwr_data)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!wwr_en && no_nwr && wrd_en) && wrd_en && !wwr_en && no_nwr)
        |-> $stable(wrd_data));

    assert_narrow_beats_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wwr_en && nwr_sel[0][0] && wrd_en) |-> (wrd_data[ENT_W-1:0] == nwr_data[0]));

    assert_low_port_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nwr_sel[0][1] && nwr_sel[1][1] && wrd_en) |-> (wrd_data[2*ENT_W-1:ENT_W] == nwr_data[0]));
endmodule

bind nibble_regfile nibrf_chk #(
    .N_ENT(N_ENT), .ENT_W(ENT_W), .N_RP(N_RP), .N_WP(N_WP)
) u_chk (.*);

// File: tb/nibble_regfile_bench.sv
// Bench: the driver task applies inputs at the falling edge and queues the expected read results.
// The monitor pops the queue and compares 3 ns later.
module nibble_regfile_bench;
    localparam int NE = 8, W = 4, NR = 8, NW = 8, WW = NE * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0][NE-1:0] nrd_sel = '0;
    logic [NR-1:0][W-1:0]  nrd_data;
    logic [NW-1:0][NE-1:0] nwr_sel = '0;
    logic [NW-1:0][W-1:0]  nwr_data = '0;
    logic                  wrd_en = 1'b0;
    logic [WW-1:0]         wrd_data;
    logic                  wwr_en = 1'b0;
    logic [WW-1:0]         wwr_data = '0;

    // staging values for the next cycle
    logic                  s_rst_n;
    logic [NR-1:0][NE-1:0] s_rsel;
    logic [NW-1:0][NE-1:0] s_wsel;
    logic [NW-1:0][W-1:0]  s_wdat;
    logic                  s_wren, s_wwen;
    logic [WW-1:0]         s_wwdat;

    logic [NE-1:0][W-1:0]  mdl;
    int tests = 0, fails = 0;
    bit done = 0;

    typedef struct {
        int          port;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    nibble_regfile u_nibble_regfile (
        .clk(clk), .rst_n(rst_n), .nrd_sel(nrd_sel), .nrd_data(nrd_data),
        .nwr_sel(nwr_sel), .nwr_data(nwr_data), .wrd_en(wrd_en), .wrd_data(wrd_data),
        .wwr_en(wwr_en), .wwr_data(wwr_data)
    );

    task automatic clear_stage();
        s_rst_n = 1'b1; s_rsel = '0; s_wsel = '0; s_wdat = '0;
        s_wren = 1'b0; s_wwen = 1'b0; s_wwdat = '0;
    endtask

    // Driver: apply the staged inputs, queue the expected reads, then advance the model.
    task automatic cyc(input string tag);
        logic [NE-1:0][W-1:0] f;
        logic [W-1:0] acc;
        item_t it;
        @(negedge clk);
        rst_n = s_rst_n; nrd_sel = s_rsel; nwr_sel = s_wsel; nwr_data = s_wdat;
        wrd_en = s_wren; wwr_en = s_wwen; wwr_data = s_wwdat;
        for (int e = 0; e < NE; e++) begin
            f[e] = s_wwen ? s_wwdat[e*W +: W] : mdl[e];
            for (int p = NW - 1; p >= 0; p--)
                if (s_wsel[p][e]) f[e] = s_wdat[p];
        end
        for (int p = 0; p < NR; p++) begin
            acc = '0;
            for (int e = 0; e < NE; e++) if (s_rsel[p][e]) acc = acc | f[e];
            it.port = p; it.exp = {28'd0, acc}; it.tag = tag;
            q.push_back(it);
        end
        it.port = NR; it.exp = s_wren ? WW'(f) : '0; it.tag = tag;
        q.push_back(it);
        mdl = s_rst_n ? f : '0;
    endtask

    // Monitor: compare every queued expectation well before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = (it.port < NR) ? {28'd0, nrd_data[it.port]} : wrd_data;
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s port %0d: actual %h expected %h", it.tag, it.port, act, it.exp);
                end
            end
        end
    end

    function automatic logic [NE-1:0] pick_sel();
        case ($urandom % 4)
            0: return '0;
            1: return NE'(1) << ($urandom % NE);
            2: return NE'($urandom);
            default: return '1;
        endcase
    endfunction

    initial begin
        mdl = '0;
        // R9: reset clears the array even after a write during reset
        clear_stage(); s_rst_n = 1'b0; s_wwen = 1'b1; s_wwdat = 32'hFFFF_FFFF;
        cyc("R9 write under reset");
        clear_stage(); s_rst_n = 1'b0; cyc("R9 reset");
        clear_stage(); s_wren = 1'b1; s_rsel = '1; cyc("R9 reset state");
        // R5 R1: wide write, then one-hot narrow reads show the nibble layout
        clear_stage(); s_wwen = 1'b1; s_wwdat = 32'h7654_3210; s_wren = 1'b1; cyc("R6 wide fwd");
        clear_stage(); s_wren = 1'b1;
        for (int p = 0; p < NR; p++) s_rsel[p] = NE'(1) << p;
        cyc("R1 R5 nibble map");
        // R3: wide read disabled gives zero
        clear_stage(); cyc("R3 wide read off");
        // R4 R6: narrow writes with same-cycle read, then readback
        clear_stage(); s_wsel[3] = 8'b0000_0100; s_wdat[3] = 4'hA;
        s_rsel[0] = 8'b0000_0100; s_wren = 1'b1; cyc("R6 narrow fwd");
        clear_stage(); s_rsel[5] = 8'b0000_0100; s_rsel[6] = 8'b0000_0011; cyc("R4 R2 readback OR");
        // R7: two narrow ports on entry 6, port 2 beats port 4
        clear_stage(); s_wsel[4] = 8'b0100_0000; s_wdat[4] = 4'h1;
        s_wsel[2] = 8'b0100_0000; s_wdat[2] = 4'hC; s_rsel[1] = 8'b0100_0000; cyc("R7 fwd");
        clear_stage(); s_wren = 1'b1; cyc("R7 stored");
        // R8: wide write with a narrow override on entry 7
        clear_stage(); s_wwen = 1'b1; s_wwdat = 32'h1111_1111; s_wsel[7] = 8'b1000_0000;
        s_wdat[7] = 4'hE; s_wren = 1'b1; cyc("R8 fwd");
        clear_stage(); s_wren = 1'b1; cyc("R8 stored");
        // R10: idle cycles hold the contents
        clear_stage(); s_wren = 1'b1; s_rsel[2] = '1; cyc("R10 hold");
        cyc("R10 hold again");
        // random mix of one-hot, multi-hot and all-zero enables
        for (int n = 0; n < 400; n++) begin
            clear_stage();
            s_rst_n = ($urandom % 64) != 0;
            for (int p = 0; p < NR; p++) s_rsel[p] = pick_sel();
            for (int p = 0; p < NW; p++) begin
                s_wsel[p] = ($urandom % 3 == 0) ? pick_sel() : '0;
                s_wdat[p] = W'($urandom);
            end
            s_wren = $urandom % 2; s_wwen = ($urandom % 4) == 0; s_wwdat = $urandom;
            cyc("R2 R4 R6 R7 R8 random");
        end
        clear_stage(); cyc("drain");
        @(negedge clk); #5;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule